// File: doc/BRIEF.md
# Register Rename Table with Free-Tag Queue

This block gives every register-writing instruction at dispatch a fresh physical register. A small table holds, for each architectural register, the physical tag it currently maps to and a ready flag. A first-in first-out queue holds the physical tags that are not allocated. One instruction is presented per cycle. The block answers combinationally in the same cycle with the physical tags and ready flags of both sources, the newly allocated destination tag, and the tag that destination was mapped to before. The retire stage uses that earlier tag later to hand the register back.

Completing instructions broadcast their physical tag, which marks the matching table entry ready. Retiring instructions return a tag to the tail of the queue. When no tag is free, a register-writing dispatch is held off with a stall output and changes nothing. Instructions with no register result pass through without consuming a tag.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i+1 and is ready, and the free queue holds tags ARCH_REGS+1 through PHYS_REGS, oldest first, so the first allocation returns tag ARCH_REGS+1.
- R2: A dispatch with `disp_valid`=1 and `disp_wr`=1 and no stall returns the queue head on `dst_tag` and remaps `disp_dst` to it from the next cycle on.
- R3: In an allocating dispatch, `prev_tag` carries the tag that `disp_dst` mapped to before this dispatch.
- R4: A dispatch with `disp_wr`=0 (store or branch) never stalls, takes no tag and leaves the mapping unchanged. The next allocation therefore receives the same tag it would have received without it.
- R5: A newly mapped entry reads not-ready until a completion broadcast (`cmpl_valid`=1) carries its tag, and it reads ready from the cycle after that broadcast on.
- R6: While the free queue is empty, a register-writing dispatch raises `stall` and leaves the mapping and the queue unchanged.
- R7: A tag released with `rel_valid`=1 joins the tail of the free queue and can be allocated from the next cycle on. Tags are handed out in release order.
- R8: Source tags are read from the mapping that holds before this cycle's destination update, so an instruction that reads and writes the same register sees the old tag.
- R9: When a completion broadcast in the same cycle carries the tag a source currently maps to, that source's ready output is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | An instruction is presented for renaming |
| disp_wr | input | 1 | The instruction writes a destination register |
| disp_dst | input | AREG_W | Architectural destination |
| disp_src1 | input | AREG_W | First architectural source |
| disp_src2 | input | AREG_W | Second architectural source |
| cmpl_valid | input | 1 | Completion broadcast present |
| cmpl_tag | input | PTAG_W | Physical tag being completed |
| rel_valid | input | 1 | Retirement releases a tag |
| rel_tag | input | PTAG_W | Physical tag returned to the free queue |
| src1_tag | output | PTAG_W | Physical tag of the first source |
| src1_rdy | output | 1 | First source value is available |
| src2_tag | output | PTAG_W | Physical tag of the second source |
| src2_rdy | output | 1 | Second source value is available |
| dst_tag | output | PTAG_W | Newly allocated destination tag |
| prev_tag | output | PTAG_W | Previous mapping of the destination |
| stall | output | 1 | Register-writing dispatch held off; queue empty |

## Verification
Assertions check on every cycle the following: an allocated tag never equals the tag it replaces, a remapped entry reads not-ready right after allocation, the queue head stays put across a stall with no release, and the queue is never popped when empty or pushed when full. Only the bench scenarios can show the rest. These are the reset mapping, the FIFO order of reallocated tags, that non-writing dispatches consume nothing, and that sources read the old mapping when they name their own destination. They also show the same-cycle completion bypass and that a stalled dispatch changes no state.

// File: rtl/rename_pkg.sv
package rename_pkg;
   // Width of a physical tag able to hold values 0..n (tag 0 is never used).
   function automatic int unsigned ptag_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction

   // Width of an index over n entries, at least one bit.
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rename_freelist.sv
module rename_freelist #(
   parameter int unsigned PTAG_W    = 4,
   parameter int unsigned FIRST_TAG = 5,
   parameter int unsigned DEPTH     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pop,
   input  logic              push,
   input  logic [PTAG_W-1:0] push_tag,
   output logic [PTAG_W-1:0] head_tag,
   output logic              empty
);
   localparam int unsigned PTR_W = rename_pkg::idx_width(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam bit          POW2  = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

   logic [PTAG_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0]  rd_q, wr_q, rd_inc, wr_inc;
   logic [CNT_W-1:0]  cnt_q;
   logic              full, do_pop, do_push;

   assign empty    = (cnt_q == '0);
   assign full     = (cnt_q == CNT_W'(DEPTH));
   assign head_tag = slot_q[rd_q];
   assign do_pop   = pop & ~empty;
   assign do_push  = push & ~full;

   generate
      if (POW2) begin : g_wrap_free
         assign rd_inc = rd_q + 1'b1;
         assign wr_inc = wr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_inc = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
         assign wr_inc = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) slot_q[i] <= PTAG_W'(FIRST_TAG + i);
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= CNT_W'(DEPTH);
      end else begin
         if (do_push) begin
            slot_q[wr_q] <= push_tag;
            wr_q         <= wr_inc;
         end
         if (do_pop) rd_q <= rd_inc;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
   end

   // R6: the allocator must never pop an empty queue
   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   // R7: retirement never returns more tags than the queue can hold
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
endmodule

// File: rtl/rename_map.sv
module rename_map #(
   parameter int unsigned ARCH_REGS = 4,
   parameter int unsigned PTAG_W    = 4,
   parameter int unsigned AREG_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AREG_W-1:0] rd_a,
   input  logic [AREG_W-1:0] rd_b,
   input  logic [AREG_W-1:0] rd_d,
   input  logic              wr_en,
   input  logic [AREG_W-1:0] wr_idx,
   input  logic [PTAG_W-1:0] wr_tag,
   input  logic              bc_valid,
   input  logic [PTAG_W-1:0] bc_tag,
   output logic [PTAG_W-1:0] tag_a,
   output logic              rdy_a,
   output logic [PTAG_W-1:0] tag_b,
   output logic              rdy_b,
   output logic [PTAG_W-1:0] tag_d
);
   logic [PTAG_W-1:0]    tag_q [ARCH_REGS];
   logic [ARCH_REGS-1:0] rdy_q;
   logic [ARCH_REGS-1:0] bc_hit;

   generate
      for (genvar g = 0; g < int'(ARCH_REGS); g++) begin : g_hit
         assign bc_hit[g] = bc_valid && (bc_tag == tag_q[g]);
      end
   endgenerate

   assign tag_a = tag_q[rd_a];
   assign tag_b = tag_q[rd_b];
   assign tag_d = tag_q[rd_d];
   assign rdy_a = rdy_q[rd_a] | bc_hit[rd_a];
   assign rdy_b = rdy_q[rd_b] | bc_hit[rd_b];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(ARCH_REGS); i++) tag_q[i] <= PTAG_W'(i + 1);
         rdy_q <= '1;
      end else begin
         rdy_q <= rdy_q | bc_hit;
         if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            rdy_q[wr_idx] <= 1'b0;
         end
      end
   end

   // R5: a freshly remapped entry reads not-ready in the following cycle
   p_fresh_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !rdy_q[$past(wr_idx)]);
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
   parameter int unsigned ARCH_REGS = 4,
   parameter int unsigned PHYS_REGS = 8,
   localparam int unsigned AREG_W   = rename_pkg::idx_width(ARCH_REGS),
   localparam int unsigned PTAG_W   = rename_pkg::ptag_width(PHYS_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   input  logic              disp_wr,
   input  logic [AREG_W-1:0] disp_dst,
   input  logic [AREG_W-1:0] disp_src1,
   input  logic [AREG_W-1:0] disp_src2,
   input  logic              cmpl_valid,
   input  logic [PTAG_W-1:0] cmpl_tag,
   input  logic              rel_valid,
   input  logic [PTAG_W-1:0] rel_tag,
   output logic [PTAG_W-1:0] src1_tag,
   output logic              src1_rdy,
   output logic [PTAG_W-1:0] src2_tag,
   output logic              src2_rdy,
   output logic [PTAG_W-1:0] dst_tag,
   output logic [PTAG_W-1:0] prev_tag,
   output logic              stall
);
   localparam int unsigned FL_DEPTH = PHYS_REGS - ARCH_REGS;

   generate
      if (ARCH_REGS < 1) begin : g_bad_arch
         $error("rename_unit: ARCH_REGS must be at least 1");
      end
      if (PHYS_REGS <= ARCH_REGS) begin : g_bad_phys
         $error("rename_unit: PHYS_REGS must exceed ARCH_REGS");
      end
   endgenerate

   logic fl_empty, alloc;

   assign stall = disp_valid & disp_wr & fl_empty;
   assign alloc = disp_valid & disp_wr & ~fl_empty;

   rename_freelist #(
      .PTAG_W   (PTAG_W),
      .FIRST_TAG(ARCH_REGS + 1),
      .DEPTH    (FL_DEPTH)
   ) u_freelist (
      .clk     (clk),
      .rst_n   (rst_n),
      .pop     (alloc),
      .push    (rel_valid),
      .push_tag(rel_tag),
      .head_tag(dst_tag),
      .empty   (fl_empty)
   );

   rename_map #(
      .ARCH_REGS(ARCH_REGS),
      .PTAG_W   (PTAG_W),
      .AREG_W   (AREG_W)
   ) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_a    (disp_src1),
      .rd_b    (disp_src2),
      .rd_d    (disp_dst),
      .wr_en   (alloc),
      .wr_idx  (disp_dst),
      .wr_tag  (dst_tag),
      .bc_valid(cmpl_valid),
      .bc_tag  (cmpl_tag),
      .tag_a   (src1_tag),
      .rdy_a   (src1_rdy),
      .tag_b   (src2_tag),
      .rdy_b   (src2_rdy),
      .tag_d   (prev_tag)
   );

   // R2: the queue head handed out is never the tag it replaces
   p_fresh_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> (dst_tag != prev_tag));
   // R6: a stall without a release leaves the queue head untouched
   p_stall_holds_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !rel_valid) |=> (dst_tag == $past(dst_tag)));
endmodule

// File: tb/rename_unit_bench.sv
`timescale 1ns/1ps
module rename_unit_bench;
   localparam int ARCH = 4;
   localparam int PHYS = 8;
   localparam int AW   = 2;
   localparam int TW   = 4;

   typedef struct {
      string   req;
      bit      stall;
      bit      alloc;
      int      s1t, s2t, dt, pt;
      bit      s1r, s2r;
   } exp_t;

   logic          clk = 0, rst_n = 0;
   logic          disp_valid = 0, disp_wr = 0, cmpl_valid = 0, rel_valid = 0;
   logic [AW-1:0] disp_dst = 0, disp_src1 = 0, disp_src2 = 0;
   logic [TW-1:0] cmpl_tag = 0, rel_tag = 0;
   logic [TW-1:0] src1_tag, src2_tag, dst_tag, prev_tag;
   logic          src1_rdy, src2_rdy, stall;

   int checks = 0, failures = 0;
   exp_t exp_q[$];
   int   mdl_tag[ARCH];
   bit   mdl_rdy[ARCH];
   int   mdl_fl[$];
   event sample_ev;

   always #4 clk = ~clk;

   rename_unit #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) u_rename_unit (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_wr(disp_wr),
      .disp_dst(disp_dst), .disp_src1(disp_src1), .disp_src2(disp_src2),
      .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .rel_valid(rel_valid),
      .rel_tag(rel_tag), .src1_tag(src1_tag), .src1_rdy(src1_rdy),
      .src2_tag(src2_tag), .src2_rdy(src2_rdy), .dst_tag(dst_tag),
      .prev_tag(prev_tag), .stall(stall));

   task automatic chk(input string req, input string what, input int act, input int expv);
      checks++;
      if (act != expv) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // Monitor: pops the oldest expectation and compares it with the ports.
   always @(sample_ev) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.req, "stall", int'(stall), int'(e.stall));
      chk(e.req, "src1_tag", int'(src1_tag), e.s1t);
      chk(e.req, "src1_rdy", int'(src1_rdy), int'(e.s1r));
      chk(e.req, "src2_tag", int'(src2_tag), e.s2t);
      chk(e.req, "src2_rdy", int'(src2_rdy), int'(e.s2r));
      if (e.alloc) begin
         chk(e.req, "dst_tag", int'(dst_tag), e.dt);
         chk(e.req, "prev_tag", int'(prev_tag), e.pt);
      end
   end

   // Driver: one cycle of stimulus, expectation from the reference model.
   task automatic step(input bit dv, input bit wr, input int dst, input int s1, input int s2,
                       input bit cv, input int ctag, input bit rv, input int rtag,
                       input string req);
      exp_t e;
      @(negedge clk);
      disp_valid = dv; disp_wr = wr; disp_dst = AW'(dst);
      disp_src1 = AW'(s1); disp_src2 = AW'(s2);
      cmpl_valid = cv; cmpl_tag = TW'(ctag); rel_valid = rv; rel_tag = TW'(rtag);
      e.req   = req;
      e.s1t   = mdl_tag[s1];
      e.s2t   = mdl_tag[s2];
      e.s1r   = mdl_rdy[s1] | (cv && ctag == mdl_tag[s1]);
      e.s2r   = mdl_rdy[s2] | (cv && ctag == mdl_tag[s2]);
      e.stall = dv && wr && (mdl_fl.size() == 0);
      e.alloc = dv && wr && !e.stall;
      e.dt    = e.alloc ? mdl_fl[0] : 0;
      e.pt    = mdl_tag[dst];
      exp_q.push_back(e);
      #2 ->sample_ev;
      @(posedge clk);
      #1;
      if (cv) for (int i = 0; i < ARCH; i++) if (mdl_tag[i] == ctag) mdl_rdy[i] = 1;
      if (e.alloc) begin
         mdl_tag[dst] = mdl_fl.pop_front();
         mdl_rdy[dst] = 0;
      end
      if (rv) mdl_fl.push_back(rtag);
   endtask

   initial begin
      #(200000 * 8);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < ARCH; i++) begin mdl_tag[i] = i + 1; mdl_rdy[i] = 1; end
      for (int t = ARCH + 1; t <= PHYS; t++) mdl_fl.push_back(t);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1: reset mapping, all ready
      step(0,0,0, 0,1, 0,0, 0,0, "R1");
      step(0,0,0, 2,3, 0,0, 0,0, "R1");
      // R2 R3 R8: write r0 while reading r0; first tag handed out is 5
      step(1,1,0, 0,1, 0,0, 0,0, "R2 R3 R8");
      // R5: remapped r0 now tag 5, not ready
      step(0,0,0, 0,0, 0,0, 0,0, "R5");
      // R4: non-writing dispatch consumes no tag
      step(1,0,0, 0,2, 0,0, 0,0, "R4");
      step(1,1,1, 1,0, 0,0, 0,0, "R4 R2");
      // R9: completion of tag 5 bypasses to the source in the same cycle
      step(0,0,0, 0,1, 1,5, 0,0, "R9");
      step(0,0,0, 0,1, 0,0, 0,0, "R5");
      // drain the queue
      step(1,1,2, 2,3, 0,0, 0,0, "R2 R3");
      step(1,1,3, 3,2, 0,0, 0,0, "R2 R3");
      // R6: queue empty, writing dispatch stalls, mapping unchanged
      step(1,1,0, 0,3, 0,0, 0,0, "R6");
      step(1,0,0, 0,2, 0,0, 0,0, "R6 R4");
      step(1,1,0, 0,1, 0,0, 1,1, "R6");
      step(0,0,0, 0,1, 0,0, 0,0, "R6");
      // R7: released tag 1 is handed out next
      step(1,1,0, 0,0, 0,0, 0,0, "R7 R3");
      step(0,0,0, 0,0, 0,0, 1,2, "R7");
      step(0,0,0, 0,0, 0,0, 1,3, "R7");
      step(1,1,1, 1,2, 0,0, 0,0, "R7");
      step(1,1,2, 2,1, 1,8, 0,0, "R7 R9");
      // release and allocate in one cycle
      step(0,0,0, 3,0, 0,0, 1,4, "R7");
      step(1,1,3, 3,3, 0,0, 1,5, "R7 R8");
      step(1,1,0, 0,3, 0,0, 0,0, "R7");
      step(1,1,1, 1,0, 0,0, 0,0, "R6");
      step(0,0,0, 0,0, 0,0, 0,0, "R5");

      @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule